// File: doc/BRIEF.md
# SAR Converter Switch-Control Sequencer

This block is the digital controller of a charge-redistribution successive-approximation converter. The converter uses a binary-weighted capacitor array and three reference levels: supply, mid-rail (half of supply) and ground. The block steps the array through its three modes. In sampling, every bottom plate follows the input while the top node is tied to mid-rail. In inversion, the top switch opens and every plate moves to mid-rail, so the top node moves to supply minus input. In redistribution, each plate in turn is connected to supply or ground, driven by the decisions already taken. The comparator decision at the end of inversion gives the most significant bit. Each redistribution step then gives one more bit, working down to the least significant.

The clock `clk` runs at twice the conversion rate. Each tick of `clk` is one half of a conversion cycle. A single tick with every switch open lies between sampling and inversion, so no plate moves from the input to a reference without first breaking. The analog array, the comparator and the references lie outside the block. The comparator reports `cmp_hi` = 1 when the top node lies above mid-rail. A conversion runs for 17 ticks after the start is accepted, and then `done` pulses with the 8-bit code.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, every plate selects mid-rail, `top_rst` is 1, `done` is 0 and `result` is 0.
- R2: In the tick after a start is accepted (`en`=1, `start`=1, controller idle), every plate selects the input (one-hot bit 0 of its 4-bit group) and `top_rst` is 1.
- R3: In the next tick every plate has all four select bits at 0 and `top_rst` is 0. A plate that selects the input is never followed, one tick later, by a different non-zero select. While `top_rst` is 0, no plate selects the input.
- R4: In the third tick every plate selects mid-rail (bit 1) and `top_rst` is 0. At the end of that tick, result bit 7 is taken as the inverse of `cmp_hi`.
- R5: Redistribution gives each of result bits 6 down to 0 two ticks. Plate k has weight 2^k and its group sits at `plate_sel[4k+3:4k]`. It selects supply (bit 2) when result bit k+1 is 1 and ground (bit 3) when it is 0. It holds that select from the first tick of bit k's trial until the conversion ends. Plates that have not yet been reached stay at mid-rail. Result bit k is the inverse of `cmp_hi` at the end of its second tick.
- R6: `done` is 1 in the 18th tick after the tick in which the start was sampled, `result` carries the new code in that same tick, and all plates return to mid-rail with `top_rst` at 1.
- R7: `done` is high for one tick only. `result` changes only in a tick where `done` is 1.
- R8: A start request while a conversion is running has no effect on the switch sequence or on the timing of `done`.
- R9: While `en` is 0, the controller stays idle or aborts a running conversion. All plates select mid-rail and `top_rst` is 1 from the next tick on. No `done` is produced and `result` keeps its old value.
- R10: With an ideal array (input mapped to code c), every input code from 0 to 255 converts to exactly c.
- R11: Every plate group has at most one select bit set in every tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, two ticks per conversion cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low parks the array and aborts |
| start | input | 1 | Conversion request, sampled when idle |
| cmp_hi | input | 1 | Comparator: top node above mid-rail |
| plate_sel | output | 28 | Per plate k, bits 4k..4k+3: input, mid-rail, supply, ground |
| top_rst | output | 1 | Top-plate switch to mid-rail closed |
| result | output | 8 | Last completed conversion code |
| done | output | 1 | One-tick completion strobe |

## Verification
The assertions take `en`, `start` and `cmp_hi` to be synchronous to `clk`. They also take `cmp_hi` to be settled whenever a decision edge arrives, and they do not depend on the comparator value during sampling or break ticks. The bench changes `en` and `start` only on the falling edge. It derives `cmp_hi` combinationally from the plate selects and from an input level that is held constant across each conversion and changed only while the controller is idle. Each input sits half a code step above a threshold, so the comparator never sees a tie.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_BREAK  = 3'd2,
    PH_INVERT = 3'd3,
    PH_REDIST = 3'd4
  } phase_e;

  localparam int SW_W   = 4;
  localparam int SW_IN  = 0;
  localparam int SW_MID = 1;
  localparam int SW_VDD = 2;
  localparam int SW_GND = 3;

  typedef logic [SW_W-1:0] sw_t;

  function automatic sw_t sw_code(input int idx);
    return sw_t'(1) << idx;
  endfunction

  // decision: top node above mid-rail means the input is below the trial level
  function automatic logic decision_bit(input logic cmp_above);
    return ~cmp_above;
  endfunction

  function automatic sw_t plate_switch(input phase_e ph, input logic reached, input logic dir);
    sw_t s;
    case (ph)
      PH_SAMPLE: s = sw_code(SW_IN);
      PH_BREAK:  s = '0;
      PH_REDIST: s = reached ? (dir ? sw_code(SW_VDD) : sw_code(SW_GND)) : sw_code(SW_MID);
      default:   s = sw_code(SW_MID);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int IW = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  output phase_e        phase,
  output logic [IW-1:0] bit_idx,
  output logic          decide_evt,
  output logic          last_evt
);

  phase_e        phase_q;
  logic [IW-1:0] idx_q;
  logic          half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      half_q  <= 1'b0;
    end else if (!en) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      half_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE:   if (start) phase_q <= PH_SAMPLE;
        PH_SAMPLE: phase_q <= PH_BREAK;
        PH_BREAK:  phase_q <= PH_INVERT;
        PH_INVERT: begin
          phase_q <= PH_REDIST;
          idx_q   <= IW'(NBITS - 2);
          half_q  <= 1'b0;
        end
        PH_REDIST: begin
          if (!half_q) begin
            half_q <= 1'b1;
          end else begin
            half_q <= 1'b0;
            if (idx_q == '0) phase_q <= PH_IDLE;
            else             idx_q   <= idx_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = phase_q;
  assign bit_idx    = idx_q;
  assign decide_evt = en && ((phase_q == PH_INVERT) || (phase_q == PH_REDIST && half_q));
  assign last_evt   = en && (phase_q == PH_REDIST) && half_q && (idx_q == '0);

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q != PH_SAMPLE)); // R8

  AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (phase_q == PH_IDLE)); // R9

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int IW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic [IW-1:0]    bit_idx,
  input  logic             decide_evt,
  input  logic             last_evt,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] result,
  output logic             done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_SAMPLE) trial <= '0;
      if (decide_evt) begin
        if (phase == PH_INVERT) trial[NBITS-1] <= decision_bit(cmp_hi);
        else                    trial[bit_idx] <= decision_bit(cmp_hi);
      end
      if (last_evt) begin
        result <= {trial[NBITS-1:1], decision_bit(cmp_hi)};
        done   <= 1'b1;
      end
    end
  end

  AST_DONE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done) |-> $stable(result)); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_evt)); // R6

endmodule

// File: rtl/sar_plate_drv.sv
module sar_plate_drv
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int NP = NBITS - 1,
  localparam int IW = $clog2(NBITS)
) (
  input  phase_e            phase,
  input  logic [IW-1:0]     bit_idx,
  input  logic [NBITS-1:1]  dir_bits,
  output logic [SW_W*NP-1:0] plate_sel,
  output logic              top_rst
);

  for (genvar k = 0; k < NP; k++) begin : g_plate
    logic reached;
    sw_t  sel;
    assign reached = (phase == PH_REDIST) && (IW'(k) >= bit_idx);
    assign sel     = plate_switch(phase, reached, dir_bits[k+1]);
    assign plate_sel[SW_W*k +: SW_W] = sel;

    always_comb begin
      AST_PLATE_ONEHOT0: assert ($onehot0(sel)); // R11
    end
  end

  assign top_rst = (phase == PH_IDLE) || (phase == PH_SAMPLE);

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int NP = NBITS - 1,
  localparam int IW = $clog2(NBITS),
  localparam int PW = SW_W * NP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             cmp_hi,
  output logic [PW-1:0]    plate_sel,
  output logic             top_rst,
  output logic [NBITS-1:0] result,
  output logic             done
);

  phase_e           phase;
  logic [IW-1:0]    bit_idx;
  logic             decide_evt;
  logic             last_evt;
  logic [NBITS-1:0] trial;

  sar_phase_seq #(.NBITS(NBITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start),
    .phase(phase), .bit_idx(bit_idx), .decide_evt(decide_evt), .last_evt(last_evt)
  );

  sar_bit_reg #(.NBITS(NBITS)) u_bits (
    .clk(clk), .rst_n(rst_n), .phase(phase), .bit_idx(bit_idx),
    .decide_evt(decide_evt), .last_evt(last_evt), .cmp_hi(cmp_hi),
    .trial(trial), .result(result), .done(done)
  );

  sar_plate_drv #(.NBITS(NBITS)) u_drv (
    .phase(phase), .bit_idx(bit_idx), .dir_bits(trial[NBITS-1:1]),
    .plate_sel(plate_sel), .top_rst(top_rst)
  );

  logic [PW-1:0] all_mid;
  logic          any_in;
  always_comb begin
    all_mid = '0;
    any_in  = 1'b0;
    for (int k = 0; k < NP; k++) begin
      all_mid[SW_W*k + SW_MID] = 1'b1;
      any_in = any_in | plate_sel[SW_W*k + SW_IN];
    end
  end

  for (genvar k = 0; k < NP; k++) begin : g_bbm
    AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
      plate_sel[SW_W*k + SW_IN] |=> ((plate_sel[SW_W*k +: SW_W] & ~sw_code(SW_IN)) == '0)); // R3
  end

  AST_PARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (top_rst && (plate_sel == all_mid))); // R9

  AST_TOP_OPEN_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_rst) |-> (!any_in)); // R3

  AST_DONE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (top_rst && (plate_sel == all_mid))); // R6

endmodule

// File: tb/sar_seq_ctrl_tb_top.sv
module sar_seq_ctrl_tb_top;
  localparam int NB = 8;
  localparam int NP = NB - 1;
  localparam int PW = 4 * NP;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, start = 1'b0;
  logic cmp_hi;
  logic [PW-1:0] plate_sel;
  logic top_rst, done;
  logic [NB-1:0] result;

  int cur_code = 0;
  int checks = 0, errors = 0, cyc = 0;
  bit chk_on = 0, finished = 0;

  always #4 clk = ~clk;

  sar_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .cmp_hi(cmp_hi),
    .plate_sel(plate_sel), .top_rst(top_rst), .result(result), .done(done)
  );

  // ideal array: doubled units, supply = 512, mid = 256, input = 2c+1
  function automatic logic analog_cmp(input logic [PW-1:0] p, input int code);
    int top = 512 - (2 * code + 1);
    for (int k = 0; k < NP; k++) begin
      if (p[4*k+2]) top += 2 * (1 << k);
      if (p[4*k+3]) top -= 2 * (1 << k);
    end
    return top > 256;
  endfunction

  function automatic logic [PW-1:0] exp_plates(input int t, input logic [NB-1:0] b);
    logic [PW-1:0] p = '0;
    for (int k = 0; k < NP; k++) begin
      if (t == 1)       p[4*k+0] = 1'b1;
      else if (t == 2)  p[4*k+:4] = 4'b0000;
      else if (t >= 4) begin
        if (k >= 6 - (t - 4) / 2) p[4*k+:4] = b[k+1] ? 4'b0100 : 4'b1000;
        else                      p[4*k+1] = 1'b1;
      end else          p[4*k+1] = 1'b1;
    end
    return p;
  endfunction

  function automatic string tag_of(input int t);
    if (t == 0) return "R9";
    if (t == 1) return "R2";
    if (t == 2) return "R3";
    if (t == 3) return "R4";
    return "R5";
  endfunction

  assign cmp_hi = analog_cmp(plate_sel, cur_code);

  // reference model: tick count since accepted start
  int m_tick = 0;
  logic [NB-1:0] m_bits = '0, m_res = '0;
  logic m_done = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tick = 0; m_bits = '0; m_res = '0; m_done = 1'b0;
    end else begin
      logic mc;
      mc = analog_cmp(exp_plates(m_tick, m_bits), cur_code);
      m_done = 1'b0;
      if (!en) m_tick = 0;
      else if (m_tick == 0) begin
        if (start) begin m_tick = 1; m_bits = '0; end
      end else begin
        if (m_tick == 3) m_bits[7] = !mc;
        else if (m_tick >= 5 && (m_tick % 2) == 1) m_bits[6 - (m_tick - 5) / 2] = !mc;
        if (m_tick == 17) begin m_res = m_bits; m_done = 1'b1; m_tick = 0; end
        else m_tick++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n && !finished) begin
      logic [PW-1:0] ep;
      ep = exp_plates(m_tick, m_bits);
      check(plate_sel === ep, tag_of(m_tick), "plate_sel", 32'(plate_sel), 32'(ep));
      check(top_rst === (m_tick <= 1), tag_of(m_tick), "top_rst", 32'(top_rst), 32'(m_tick <= 1));
      check(done === m_done, "R6", "done", 32'(done), 32'(m_done));
      check(result === m_res, "R7", "result", 32'(result), 32'(m_res));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL R10 watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_conv(input int c, input bit hold);
    int n = 0;
    cur_code = c;
    start = 1'b1;
    @(negedge clk);
    if (!hold) start = 1'b0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(n == 17, "R6", "latency", 32'(n + 1), 32'd18);
    check(result === NB'(c), "R10", "code", 32'(result), 32'(c));
    @(negedge clk);
    check(done === 1'b0, "R7", "done width", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(top_rst === 1'b1, "R1", "top_rst", 32'(top_rst), 32'd1);
    check(plate_sel === exp_plates(0, '0), "R1", "plate_sel", 32'(plate_sel), 32'(exp_plates(0, '0)));
    check(done === 1'b0, "R1", "done", 32'(done), 32'd0);
    check(result === '0, "R1", "result", 32'(result), 32'd0);
    chk_on = 1;
    // start while disabled is ignored: R9
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(top_rst === 1'b1, "R9", "idle top_rst", 32'(top_rst), 32'd1);
    en = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 256; c++) begin
      if (c == 100) begin
        cur_code = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(plate_sel === exp_plates(0, '0), "R9", "abort park", 32'(plate_sel), 32'(exp_plates(0, '0)));
        check(top_rst === 1'b1, "R9", "abort top_rst", 32'(top_rst), 32'd1);
        repeat (20) @(negedge clk);
        check(done === 1'b0, "R9", "abort done", 32'(done), 32'd0);
        check(result === NB'(99), "R9", "abort result", 32'(result), 32'd99);
        en = 1'b1;
        @(negedge clk);
      end
      // held start exercises R8
      run_conv(c, (c % 37) == 3);
    end
    repeat (5) @(negedge clk);
    check(result === NB'(255), "R7", "result hold", 32'(result), 32'd255);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule